// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches transfers on an external bus and flags any cycle whose acknowledge is late. A transfer-start opens a timing window. A final acknowledge closes it. An acknowledge that arrives while the burst indication is high closes only the current beat and opens a fresh window at once. Time is counted in prescaled ticks, one tick every eight system clocks. The prescaler is cleared whenever a window opens, so every window starts on a clean boundary. When the programmed number of ticks passes without an acknowledge, the block sends a single-cycle transfer-error pulse to the bus controller. It then goes idle until the next transfer-start.

Monitoring is normally switched on by an enable bit. It is forced on while the freeze input is high or a debug request is pending, whatever the enable bit says. When the monitor is not active, it drops any window it has open and ignores transfer-starts. All pins are plain level signals sampled on the rising clock edge. The block carries no data stream, so it has no valid/ready handshake.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset, `tea_o` is low and no window is open.
- R2: With limit L between 1 and 255, a transfer-start accepted at edge E0 with no acknowledge afterwards makes `tea_o` high for exactly one cycle, after edge E0 + 8·L.
- R3: A limit of 0 behaves like a limit of 1: the error comes on the first tick, 8 clocks after the start.
- R4: A non-burst acknowledge sampled before the window expires closes the window, and no error follows.
- R5: An acknowledge sampled on the same edge at which the window would expire wins, and no error is raised.
- R6: An acknowledge sampled while `burst_i` is high restarts the full window from that edge.
- R7: After the error pulse the monitor stays idle, and it raises no further error until a new transfer-start.
- R8: While `enable_i`, `freeze_i` and `dbg_pend_i` are all low, transfer-starts are ignored and any open window is dropped.
- R9: A high `freeze_i` or a high `dbg_pend_i` makes the monitor active even while `enable_i` is low.
- R10: With a limit of 255, the error comes 2040 clocks after the start.
- R11: A transfer-start that arrives while a window is already open restarts that window.
- R12: An acknowledge sampled while no window is open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start_i | input | 1 | Transfer begins this cycle |
| xfer_ack_i | input | 1 | Transfer acknowledge this cycle |
| burst_i | input | 1 | High when the acknowledged beat is not the last beat of a burst |
| timeout_val_i | input | LIMIT_W (8) | Limit, counted in prescaled ticks |
| enable_i | input | 1 | Turns monitoring on |
| freeze_i | input | 1 | Freeze; forces monitoring on |
| dbg_pend_i | input | 1 | Debug request pending; forces monitoring on |
| tea_o | output | 1 | One-cycle transfer-error pulse |

## Verification
The bench runs single transfers with limits 0, 3 and 255. These runs separate the tick arithmetic, the zero-limit rule and the maximum window length. Acknowledges are placed early, on the exact expiry edge, and while idle. These cases show whether the acknowledge is given priority over expiry, and whether an acknowledge with no window open is ignored. Burst beats, a repeated start, and runs that toggle the enable, freeze and debug inputs show whether the window restarts correctly and whether the forced-on rule works. A behavioural model predicts `tea_o` on every clock, and the bench counts pulses for each scenario.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_t;
endpackage

// File: rtl/bmon_prescaler.sv
module bmon_prescaler #(
  parameter int PRESCALE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] phase;

  assign tick = run && (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase <= '0;
    end else if (run) begin
      phase <= (phase == LAST) ? '0 : phase + PW'(1);
    end
  end

  generate
    if (PRESCALE > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/bmon_tick_counter.sv
module bmon_tick_counter #(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               tick,
  input  logic [LIMIT_W-1:0] limit,
  output logic               expire
);
  logic [LIMIT_W-1:0] count;
  logic [LIMIT_W:0]   next_count;

  assign next_count = {1'b0, count} + (LIMIT_W+1)'(1);
  assign expire     = tick && (next_count >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
    end else if (tick && !next_count[LIMIT_W]) begin
      count <= next_count[LIMIT_W-1:0];
    end
  end

  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(count)); // R2
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor #(
  parameter int PRESCALE = 8,
  parameter int LIMIT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_start_i,
  input  logic               xfer_ack_i,
  input  logic               burst_i,
  input  logic [LIMIT_W-1:0] timeout_val_i,
  input  logic               enable_i,
  input  logic               freeze_i,
  input  logic               dbg_pend_i,
  output logic               tea_o
);
  import bmon_pkg::*;

  win_state_t state, state_nx;
  logic active, busy, restart, run, tick, expire, tea_nx;

  assign active  = enable_i || freeze_i || dbg_pend_i;
  assign busy    = (state == WIN_OPEN);
  assign restart = active && (xfer_start_i || (busy && xfer_ack_i && burst_i));
  assign run     = active && busy && !xfer_ack_i && !xfer_start_i;
  assign tea_nx  = run && expire;

  always_comb begin
    state_nx = state;
    if (!active)                state_nx = WIN_IDLE;
    else if (xfer_start_i)      state_nx = WIN_OPEN;
    else if (busy && xfer_ack_i) state_nx = burst_i ? WIN_OPEN : WIN_IDLE;
    else if (tea_nx)            state_nx = WIN_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WIN_IDLE;
      tea_o <= 1'b0;
    end else begin
      state <= state_nx;
      tea_o <= tea_nx;
    end
  end

  bmon_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .tick(tick)
  );

  bmon_tick_counter #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(restart || !busy), .tick(tick),
    .limit(timeout_val_i), .expire(expire)
  );

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tea_o |=> !tea_o); // R2
  AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_ack_i) |=> !tea_o); // R5
  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!tea_o && !busy)); // R8
  AST_IDLE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    tea_o |-> !busy); // R7
  AST_IDLE_NO_TEA: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !tea_o); // R12
endmodule

// File: tb/sim_bus_timeout_monitor.sv
`timescale 1ns/1ps
module sim_bus_timeout_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ack = 1'b0, burst = 1'b0;
  logic [7:0] lim = 8'd3;
  logic en = 1'b0, frz = 1'b0, dbg = 1'b0;
  logic tea;

  int checks = 0, fails = 0, pulses = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_timeout_monitor u0 (
    .clk(clk), .rst_n(rst_n), .xfer_start_i(start), .xfer_ack_i(ack),
    .burst_i(burst), .timeout_val_i(lim), .enable_i(en), .freeze_i(frz),
    .dbg_pend_i(dbg), .tea_o(tea)
  );

  // behavioural reference
  bit m_busy = 0, m_tea = 0;
  int m_el = 0;
  always @(posedge clk) begin
    int win;
    win = (lim == 0) ? 8 : 8 * int'(lim);
    m_tea = 0;
    if (!rst_n) begin
      m_busy = 0;
    end else if (!(en || frz || dbg)) begin
      m_busy = 0;
    end else if (start) begin
      m_busy = 1; m_el = 0;
    end else if (m_busy && ack) begin
      if (burst) m_el = 0; else m_busy = 0;
    end else if (m_busy) begin
      m_el++;
      if (m_el == win) begin m_tea = 1; m_busy = 0; end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (tea !== m_tea) begin
      fails++;
      $display("FAIL %s: tea_o actual=%b expected=%b at %0t", cur_req, tea, m_tea, $time);
    end
    if (tea === 1'b1) pulses++;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic do_ack(input logic b);
    ack = 1'b1; burst = b; @(negedge clk); ack = 1'b0; burst = 1'b0;
  endtask

  task automatic expect_pulses(input string req, input int exp);
    #1;
    checks++;
    if (pulses != exp) begin
      fails++;
      $display("FAIL %s: pulse count actual=%0d expected=%0d", req, pulses, exp);
    end
    pulses = 0;
  endtask

  initial begin
    cyc(4);
    expect_pulses("R1", 0);
    rst_n = 1'b1; en = 1'b1;
    cyc(2);

    cur_req = "R2"; lim = 8'd3; do_start(); cyc(40); expect_pulses("R2", 1);
    cur_req = "R3"; lim = 8'd0; do_start(); cyc(20); expect_pulses("R3", 1);
    cur_req = "R4"; lim = 8'd2; do_start(); cyc(9); do_ack(1'b0); cyc(30);
    expect_pulses("R4", 0);
    // start sampled at E0; ack present at E16, the expiry edge
    cur_req = "R5"; lim = 8'd2; do_start(); cyc(15); do_ack(1'b0); cyc(30);
    expect_pulses("R5", 0);
    cur_req = "R6"; lim = 8'd2; do_start(); cyc(12); do_ack(1'b1); cyc(12);
    do_ack(1'b1); cyc(12); do_ack(1'b0); cyc(30); expect_pulses("R6_closed", 0);
    do_start(); cyc(5); do_ack(1'b1); cyc(40); expect_pulses("R6_beat", 1);
    cur_req = "R7"; lim = 8'd1; do_start(); cyc(60); expect_pulses("R7", 1);
    cur_req = "R8"; en = 1'b0; lim = 8'd1; do_start(); cyc(30); expect_pulses("R8_start", 0);
    en = 1'b1; do_start(); cyc(3); en = 1'b0; cyc(30); en = 1'b1; cyc(20);
    expect_pulses("R8_drop", 0);
    cur_req = "R9"; en = 1'b0; frz = 1'b1; do_start(); cyc(20); expect_pulses("R9_freeze", 1);
    frz = 1'b0; dbg = 1'b1; do_start(); cyc(20); expect_pulses("R9_debug", 1);
    dbg = 1'b0; en = 1'b1;
    cur_req = "R10"; lim = 8'd255; do_start(); cyc(2038);
    expect_pulses("R10_early", 0); cyc(10); expect_pulses("R10", 1);
    cur_req = "R11"; lim = 8'd2; do_start(); cyc(10); do_start(); cyc(12);
    expect_pulses("R11_early", 0); cyc(20); expect_pulses("R11", 1);
    cur_req = "R12"; do_ack(1'b0); do_ack(1'b1); cyc(30); expect_pulses("R12", 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule